// File: doc/BRIEF.md
# Branch Opcode Type Classifier

This block sorts one recorded control-flow change into a class bitmask. It takes the opcode bytes, the reg field of the ModRM byte and a flag saying whether the call immediate is zero. It also takes flags for a zero source address and a zero target address, the privilege level at both ends, and a transaction-abort flag. A branch-sampling filter uses it to decide which recorded entries match a requested set of branch kinds. The filter ANDs the returned mask against its request mask.

The block decodes nothing from memory. Whatever fetches the instruction bytes passes `op_ok` low when that fetch fails. The result is registered: a classification presented with `in_valid` appears on `br_class` one clock later, marked by `out_valid`. The result then stays on `br_class` until the next valid input.

Top module: `bclass_top`

## Requirements
- R1: `br_class` is an 18-bit class mask with this layout. Bit 0 is target user and bit 1 is target kernel. Bit 2 is call, 3 is return, 4 is system call, 5 is system-call return, 6 is software interrupt, 7 is interrupt return, 8 is conditional and 9 is jump. Bit 10 is hardware interrupt, 11 is indirect call, 12 is abort, 15 is zero-length call and 17 is indirect jump. Bits 13, 14 and 16 are always 0.
- R2: When `src_is_zero` or `dst_is_zero` is 1, the result is 0, whatever the other inputs are.
- R3: When both addresses are non-zero and `tx_abort` is 1, the result is bit 12 plus the target privilege bit, and no decoding is done.
- R4: When both addresses are non-zero, `tx_abort` is 0 and `op_ok` is 0, the result is bit 12 alone (0x01000).
- R5: When `opc0` is 0x0F, `opc1` selects the class. 0x05 and 0x34 give system call, and 0x07 and 0x35 give system-call return. 0x80 to 0x8F give conditional, and any other value gives none.
- R6: Single-byte opcodes decode as follows. 0x70–0x7F and 0xE0–0xE3 are conditional, and 0xC2, 0xC3, 0xCA and 0xCB are return. 0xCF is interrupt return and 0xCC–0xCE are software interrupt. 0x9A is call and 0xE9–0xEB are jump. Any opcode not listed gives none.
- R7: Opcode 0xE8 gives zero-length call when `imm_is_zero` is 1 and call when it is 0.
- R8: For opcode 0xFF, `modrm_reg` selects the class: 2 or 3 is indirect call, 4 or 5 is indirect jump, and any other value is none. `modrm_reg` has no effect for any other opcode.
- R9: Some decoded results are replaced by hardware interrupt (bit 10). This happens when `src_kern` is 0 (user source), `dst_kern` is 1 (kernel target), and the decoded type is neither system call nor software interrupt. The replacement also applies when the decoded type is none.
- R10: Every decoded result other than none also carries bit 1 when `dst_kern` is 1, or bit 0 when it is 0. A result of none stays 0.
- R11: After a clock edge with `rst_n` low, `out_valid` and `br_class` are 0. A result appears in the cycle after `in_valid`, with `out_valid` high for exactly that cycle. While `in_valid` is 0, `br_class` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input fields carry a record to classify |
| src_is_zero | input | 1 | Source address of the record is zero |
| dst_is_zero | input | 1 | Target address of the record is zero |
| src_kern | input | 1 | Source privilege, 1 = kernel, 0 = user |
| dst_kern | input | 1 | Target privilege, 1 = kernel, 0 = user |
| tx_abort | input | 1 | Record marks a transaction abort |
| op_ok | input | 1 | Opcode bytes were fetched successfully |
| opc0 | input | 8 | First opcode byte |
| opc1 | input | 8 | Second opcode byte, used after 0x0F |
| modrm_reg | input | 3 | Reg field (bits 5:3) of the ModRM byte |
| imm_is_zero | input | 1 | Immediate of a relative call is zero |
| out_valid | output | 1 | `br_class` was updated this cycle |
| br_class | output | 18 | Class mask, layout as in R1 |

## Verification
The assertions assume that every input field is driven to a known 0 or 1 in any cycle where `in_valid` is high, since each property uses the sampled inputs of that cycle. They also assume the privilege flags describe a single record, so a kernel-to-user record is never confused with the reverse. The stimulus drives every field on each valid cycle, including fields the case ignores, and keeps fixed values while idle. The reset check holds `in_valid` low, which keeps the one-cycle relation between input and output intact from the first edge.

// File: rtl/bclass_pkg.sv
// Package: class-mask layout shared by the classifier and its users.
// Assumes an 18-bit mask; bit positions are decoded by the sampling filter.
package bclass_pkg;
    localparam int CLS_W      = 18;
    localparam int B_USER     = 0;
    localparam int B_KERN     = 1;
    localparam int B_CALL     = 2;
    localparam int B_RET      = 3;
    localparam int B_SYSC     = 4;
    localparam int B_SYSR     = 5;
    localparam int B_SWINT    = 6;
    localparam int B_IRET     = 7;
    localparam int B_COND     = 8;
    localparam int B_JMP      = 9;
    localparam int B_HWINT    = 10;
    localparam int B_ICALL    = 11;
    localparam int B_ABORT    = 12;
    localparam int B_ZCALL    = 15;
    localparam int B_IJMP     = 17;

    typedef logic [CLS_W-1:0] cls_t;

    // Mask with a single class bit set.
    function automatic cls_t cls_bit(input int idx);
        cls_t m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/bclass_opdec.sv
// Opcode decoder: maps opcode bytes to a single raw class bit, or none.
// Assumes bytes are valid; privilege and abort handling happen downstream.
module bclass_opdec
    import bclass_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int REG_W  = 3
) (
    input  logic [BYTE_W-1:0] opc0,
    input  logic [BYTE_W-1:0] opc1,
    input  logic [REG_W-1:0]  modrm_reg,
    input  logic              imm_is_zero,
    output cls_t              raw_cls
);
    cls_t esc_cls;
    cls_t grp_cls;

    // Second-byte decode behind the 0x0F escape.
    always_comb begin
        case (opc1) inside
            8'h05, 8'h34:   esc_cls = cls_bit(B_SYSC);
            8'h07, 8'h35:   esc_cls = cls_bit(B_SYSR);
            [8'h80:8'h8F]:  esc_cls = cls_bit(B_COND);
            default:        esc_cls = '0;
        endcase
    end

    // Group decode of 0xFF by ModRM reg field.
    always_comb begin
        case (modrm_reg)
            3'd2, 3'd3: grp_cls = cls_bit(B_ICALL);
            3'd4, 3'd5: grp_cls = cls_bit(B_IJMP);
            default:    grp_cls = '0;
        endcase
    end

    // Primary opcode decode.
    always_comb begin
        case (opc0) inside
            8'h0F:                      raw_cls = esc_cls;
            [8'h70:8'h7F], [8'hE0:8'hE3]: raw_cls = cls_bit(B_COND);
            8'hC2, 8'hC3, 8'hCA, 8'hCB: raw_cls = cls_bit(B_RET);
            8'hCF:                      raw_cls = cls_bit(B_IRET);
            [8'hCC:8'hCE]:              raw_cls = cls_bit(B_SWINT);
            8'h9A:                      raw_cls = cls_bit(B_CALL);
            8'hE8:                      raw_cls = imm_is_zero ? cls_bit(B_ZCALL) : cls_bit(B_CALL);
            [8'hE9:8'hEB]:              raw_cls = cls_bit(B_JMP);
            8'hFF:                      raw_cls = grp_cls;
            default:                    raw_cls = '0;
        endcase
    end
endmodule

// File: rtl/bclass_privfix.sv
// Privilege resolver: applies the zero-address, abort and fetch-failure
// early exits, the user-to-kernel interrupt override and the target tag.
// Assumes raw_cls holds at most one class bit.
module bclass_privfix
    import bclass_pkg::*;
(
    input  cls_t raw_cls,
    input  logic src_is_zero,
    input  logic dst_is_zero,
    input  logic src_kern,
    input  logic dst_kern,
    input  logic tx_abort,
    input  logic op_ok,
    output cls_t fin_cls
);
    cls_t tgt_tag;
    cls_t typed;
    logic ring_in;

    // Target privilege tag and ring-entry detection.
    always_comb begin
        tgt_tag = dst_kern ? cls_bit(B_KERN) : cls_bit(B_USER);
        ring_in = !src_kern && dst_kern;
    end

    // Interrupt override, then privilege tagging of non-empty results.
    always_comb begin
        typed = raw_cls;
        if (ring_in && !raw_cls[B_SYSC] && !raw_cls[B_SWINT])
            typed = cls_bit(B_HWINT);
        if (typed != '0)
            typed = typed | tgt_tag;
    end

    // Early-exit priority: zero address, abort, failed fetch, decode.
    always_comb begin
        if (src_is_zero || dst_is_zero)
            fin_cls = '0;
        else if (tx_abort)
            fin_cls = cls_bit(B_ABORT) | tgt_tag;
        else if (!op_ok)
            fin_cls = cls_bit(B_ABORT);
        else
            fin_cls = typed;
    end
endmodule

// File: rtl/bclass_top.sv
// Branch class classifier top: decode plus resolve, registered once.
// Assumes inputs are known whenever in_valid is high; result follows
// one cycle later and holds until the next valid input.
module bclass_top
    import bclass_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int REG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              src_is_zero,
    input  logic              dst_is_zero,
    input  logic              src_kern,
    input  logic              dst_kern,
    input  logic              tx_abort,
    input  logic              op_ok,
    input  logic [BYTE_W-1:0] opc0,
    input  logic [BYTE_W-1:0] opc1,
    input  logic [REG_W-1:0]  modrm_reg,
    input  logic              imm_is_zero,
    output logic              out_valid,
    output logic [CLS_W-1:0]  br_class
);
    cls_t raw_cls;
    cls_t fin_cls;

    bclass_opdec #(.BYTE_W(BYTE_W), .REG_W(REG_W)) u_dec (
        .opc0(opc0), .opc1(opc1), .modrm_reg(modrm_reg),
        .imm_is_zero(imm_is_zero), .raw_cls(raw_cls)
    );

    bclass_privfix u_fix (
        .raw_cls(raw_cls), .src_is_zero(src_is_zero), .dst_is_zero(dst_is_zero),
        .src_kern(src_kern), .dst_kern(dst_kern), .tx_abort(tx_abort),
        .op_ok(op_ok), .fin_cls(fin_cls)
    );

    // Output register: capture on valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            br_class  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                br_class <= fin_cls;
        end
    end

    // R2: zero address yields an empty mask.
    a_r2_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (src_is_zero || dst_is_zero) |=> br_class == '0);

    // R3: abort yields abort plus target privilege.
    a_r3_abort: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !src_is_zero && !dst_is_zero && tx_abort
        |=> br_class == (cls_bit(B_ABORT) | (dst_kern ? cls_bit(B_KERN) : cls_bit(B_USER))) ||
            (br_class == (cls_bit(B_ABORT) | ($past(dst_kern) ? cls_bit(B_KERN) : cls_bit(B_USER)))));

    // R9: user-to-kernel decode lands on interrupt, syscall or software interrupt.
    a_r9_ring_entry: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !src_is_zero && !dst_is_zero && !tx_abort && op_ok && !src_kern && dst_kern
        |=> br_class[B_HWINT] || br_class[B_SYSC] || br_class[B_SWINT]);

    // R10: a decoded non-empty result carries exactly the target privilege bit.
    a_r10_tgt_tag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !src_is_zero && !dst_is_zero && !tx_abort && op_ok
        |=> br_class == '0 || (br_class[B_KERN] == $past(dst_kern) && br_class[B_USER] == !$past(dst_kern)));

    // R1: at most one type bit outside the privilege pair, unused bits clear.
    a_r1_one_type: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(br_class[CLS_W-1:2]) && !br_class[13] && !br_class[14] && !br_class[16]);

    // R11: output valid tracks input valid by one cycle; class holds when idle.
    a_r11_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid && rst_n |=> $stable(br_class));
endmodule

// File: tb/bclass_top_test.sv
module bclass_top_test;
    localparam logic [17:0] U = 18'h00001, K = 18'h00002, CALL = 18'h00004, RET = 18'h00008;
    localparam logic [17:0] SYSC = 18'h00010, SYSR = 18'h00020, SWI = 18'h00040, IRET = 18'h00080;
    localparam logic [17:0] COND = 18'h00100, JMP = 18'h00200, HWI = 18'h00400, ICALL = 18'h00800;
    localparam logic [17:0] ABT = 18'h01000, ZCALL = 18'h08000, IJMP = 18'h20000;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic src_is_zero = 1'b0, dst_is_zero = 1'b0, src_kern = 1'b0, dst_kern = 1'b0;
    logic tx_abort = 1'b0, op_ok = 1'b1, imm_is_zero = 1'b0;
    logic [7:0] opc0 = 8'h90, opc1 = 8'h00;
    logic [2:0] modrm_reg = 3'd0;
    logic out_valid;
    logic [17:0] br_class;

    int total = 0, bad = 0, cycles = 0;
    logic [17:0] exp_q[$];
    string tag_q[$];
    logic [17:0] last_exp = '0;

    always #2 clk = ~clk;

    bclass_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_is_zero(src_is_zero), .dst_is_zero(dst_is_zero),
        .src_kern(src_kern), .dst_kern(dst_kern), .tx_abort(tx_abort),
        .op_ok(op_ok), .opc0(opc0), .opc1(opc1), .modrm_reg(modrm_reg),
        .imm_is_zero(imm_is_zero), .out_valid(out_valid), .br_class(br_class)
    );

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    // Driver: apply one record and queue its expected class.
    task automatic drive(input string req, input logic sz, input logic dz, input logic fk,
                         input logic tk, input logic ab, input logic ok, input logic [7:0] o0,
                         input logic [7:0] o1, input logic [2:0] m, input logic iz,
                         input logic [17:0] exp);
        @(negedge clk);
        src_is_zero = sz; dst_is_zero = dz; src_kern = fk; dst_kern = tk;
        tx_abort = ab; op_ok = ok; opc0 = o0; opc1 = o1; modrm_reg = m; imm_is_zero = iz;
        in_valid = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        last_exp = exp;
    endtask

    // Monitor: compare each produced result with the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) check("R11 unexpected out_valid", 18'h1, 18'h0);
            else check(tag_q.pop_front(), br_class, exp_q.pop_front());
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset out_valid", {17'b0, out_valid}, 18'h0);
        check("R11 reset class", br_class, 18'h0);
        rst_n = 1'b1;
        // R2 zero addresses
        drive("R2 src zero", 1,0,0,0,0,1, 8'h74,8'h00,0,0, 18'h0);
        drive("R2 dst zero", 0,1,1,1,1,1, 8'hC3,8'h00,0,0, 18'h0);
        // R3 abort
        drive("R3 abort kern", 0,0,0,1,1,1, 8'h74,8'h00,0,0, ABT|K);
        drive("R3 abort user", 0,0,1,0,1,0, 8'h90,8'h00,0,0, ABT|U);
        // R4 fetch failure
        drive("R4 no opcode", 0,0,0,0,0,0, 8'h74,8'h00,0,0, ABT);
        drive("R4 no opcode ring", 0,0,0,1,0,0, 8'h74,8'h00,0,0, ABT);
        // R5 escape page
        drive("R5 0F05", 0,0,0,0,0,1, 8'h0F,8'h05,0,0, SYSC|U);
        drive("R5 0F34", 0,0,1,1,0,1, 8'h0F,8'h34,0,0, SYSC|K);
        drive("R5 0F07", 0,0,1,0,0,1, 8'h0F,8'h07,0,0, SYSR|U);
        drive("R5 0F35", 0,0,1,0,0,1, 8'h0F,8'h35,0,0, SYSR|U);
        drive("R5 0F85", 0,0,0,0,0,1, 8'h0F,8'h85,0,0, COND|U);
        drive("R5 0F8F", 0,0,1,1,0,1, 8'h0F,8'h8F,0,0, COND|K);
        drive("R5 0F80", 0,0,0,0,0,1, 8'h0F,8'h80,0,0, COND|U);
        drive("R5 0F90 none", 0,0,0,0,0,1, 8'h0F,8'h90,0,0, 18'h0);
        drive("R5 0F7F none", 0,0,0,0,0,1, 8'h0F,8'h7F,0,0, 18'h0);
        // R6 single byte
        drive("R6 74", 0,0,0,0,0,1, 8'h74,8'h00,0,0, COND|U);
        drive("R6 70", 0,0,0,0,0,1, 8'h70,8'h00,0,0, COND|U);
        drive("R6 7F", 0,0,0,0,0,1, 8'h7F,8'h00,0,0, COND|U);
        drive("R6 E0", 0,0,0,0,0,1, 8'hE0,8'h00,0,0, COND|U);
        drive("R6 E3", 0,0,0,0,0,1, 8'hE3,8'h00,0,0, COND|U);
        drive("R6 E4 none", 0,0,0,0,0,1, 8'hE4,8'h00,0,0, 18'h0);
        drive("R6 C2", 0,0,0,0,0,1, 8'hC2,8'h00,0,0, RET|U);
        drive("R6 C3", 0,0,1,1,0,1, 8'hC3,8'h00,0,0, RET|K);
        drive("R6 CA", 0,0,0,0,0,1, 8'hCA,8'h00,0,0, RET|U);
        drive("R6 CB", 0,0,0,0,0,1, 8'hCB,8'h00,0,0, RET|U);
        drive("R6 CF", 0,0,1,0,0,1, 8'hCF,8'h00,0,0, IRET|U);
        drive("R6 CC", 0,0,0,0,0,1, 8'hCC,8'h00,0,0, SWI|U);
        drive("R6 CE", 0,0,0,0,0,1, 8'hCE,8'h00,0,0, SWI|U);
        drive("R6 9A", 0,0,0,0,0,1, 8'h9A,8'h00,0,0, CALL|U);
        drive("R6 E9", 0,0,0,0,0,1, 8'hE9,8'h00,0,0, JMP|U);
        drive("R6 EB", 0,0,1,1,0,1, 8'hEB,8'h00,0,0, JMP|K);
        drive("R6 EC none", 0,0,0,0,0,1, 8'hEC,8'h00,0,0, 18'h0);
        drive("R6 90 none", 0,0,0,0,0,1, 8'h90,8'h05,3,1, 18'h0);
        // R7 relative call
        drive("R7 E8 zero imm", 0,0,0,0,0,1, 8'hE8,8'h00,0,1, ZCALL|U);
        drive("R7 E8 nonzero", 0,0,0,0,0,1, 8'hE8,8'h00,0,0, CALL|U);
        // R8 group FF
        drive("R8 FF reg2", 0,0,0,0,0,1, 8'hFF,8'h00,2,0, ICALL|U);
        drive("R8 FF reg3", 0,0,1,1,0,1, 8'hFF,8'h00,3,0, ICALL|K);
        drive("R8 FF reg4", 0,0,0,0,0,1, 8'hFF,8'h00,4,0, IJMP|U);
        drive("R8 FF reg5", 0,0,0,0,0,1, 8'hFF,8'h00,5,0, IJMP|U);
        drive("R8 FF reg0 none", 0,0,0,0,0,1, 8'hFF,8'h00,0,0, 18'h0);
        drive("R8 FF reg7 none", 0,0,0,0,0,1, 8'hFF,8'h00,7,0, 18'h0);
        drive("R8 reg ignored", 0,0,0,0,0,1, 8'hE9,8'h00,2,0, JMP|U);
        // R9 ring entry override
        drive("R9 cond to irq", 0,0,0,1,0,1, 8'h74,8'h00,0,0, HWI|K);
        drive("R9 none to irq", 0,0,0,1,0,1, 8'h90,8'h00,0,0, HWI|K);
        drive("R9 syscall kept", 0,0,0,1,0,1, 8'h0F,8'h05,0,0, SYSC|K);
        drive("R9 swint kept", 0,0,0,1,0,1, 8'hCD,8'h00,0,0, SWI|K);
        drive("R9 k to u no override", 0,0,1,0,0,1, 8'h74,8'h00,0,0, COND|U);
        // R10 tag
        drive("R10 kern tag", 0,0,1,1,0,1, 8'h74,8'h00,0,0, COND|K);
        drive("R10 none untagged", 0,0,1,1,0,1, 8'hE4,8'h00,0,0, 18'h0);
        drive("R1 last", 0,0,1,1,0,1, 8'hCF,8'h00,0,0, IRET|K);
        // R11 hold while idle
        @(negedge clk);
        in_valid = 1'b0; opc0 = 8'h74; dst_kern = 1'b0; src_kern = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11 idle out_valid", {17'b0, out_valid}, 18'h0);
        check("R11 hold class", br_class, last_exp);
        check("R11 queue drained", 18'(exp_q.size()), 18'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule